// File: doc/BRIEF.md
# Serial Calendar Clock Command Interface

This block models a calendar clock that software drives through one byte-wide command port. Three bits of each written byte act as wires toward the clock: a command strobe, a shift clock and a serial data line. The block finds edges on these wires by comparing each new byte with the byte written before it. A falling strobe edge latches a command from the previously written byte. A rising shift-clock edge moves one bit through a 48-bit shift register.

There are two kinds of command. A mode command sets the operating mode. Mode 3 copies the current date and time from a parallel input bus into the shift register as packed fields. Mode 1 lets shift-clock edges move data through the register. A rate command starts a periodic single-cycle interrupt tick at one of three rates, or stops it. The pulse periods are derived from a system clock frequency parameter.

The serial output is bit 0 of the shift register. It appears in a status byte whose upper five bits read as ones.

Top module: `calclk_top`

## Requirements
- R1: Bit 3 of the command byte is the strobe, bit 4 the shift clock and bit 5 the serial data-in. A command is latched from the previously written byte only when that byte had bit 3 set and bit 4 clear, and the new byte has bit 3 clear.
- R2: When the latched command has bit 2 set, its bits 1:0 select the tick rate. Rate 0 gives a period of CLK_HZ/64 clock cycles, rate 1 gives CLK_HZ/256, rate 2 gives CLK_HZ/2048, and rate 3 stops the tick.
- R3: When the tick is started from the stopped state, the first tick is seen exactly one period after the clock edge that accepts the command. Every tick is high for exactly one cycle.
- R4: When the latched command has bit 2 clear, its bits 1:0 become the operating mode. A rate command leaves the mode unchanged.
- R5: Mode 3 loads the shift register with the following fields:
  - bits 7:0: seconds
  - bits 15:8: minutes
  - bits 23:16: hours
  - bits 31:24: day of month
  - bits 35:32: weekday
  - bits 39:36: month
  - bits 47:40: year
- R6: In mode 1, each rising shift-clock edge does two things. It ORs the data-in bit of the previously written byte into bit 40, and then it shifts the register right by one place.
- R7: The status byte is 0xF8 OR bit 0 of the shift register. It reflects a write from the cycle after that write.
- R8: In any mode other than 1, rising shift-clock edges leave the shift register unchanged.
- R9: After reset, the stored command byte is 0x10, the mode is 0, the tick is stopped and the shift register is zero. The status byte therefore reads 0xF8.
- R10: A strobe falling edge is ignored when the previous byte had the shift clock high. In that case neither the mode, the rate nor the shift register changes.
- R11: Seconds, minutes, hours, day of month and the two-digit year are loaded as two BCD digits, with the tens digit in the upper nibble. Weekday and month are loaded in plain binary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_we | input | 1 | Command byte write enable |
| cmd_wdata | input | 8 | Command byte written |
| now_sec | input | 6 | Current seconds, binary 0-59 |
| now_min | input | 6 | Current minutes, binary 0-59 |
| now_hour | input | 5 | Current hours, binary 0-23 |
| now_mday | input | 5 | Current day of month, binary 1-31 |
| now_wday | input | 3 | Current weekday, binary 0-6 |
| now_mon | input | 4 | Current month, binary |
| now_year | input | 7 | Current two-digit year, binary 0-99 |
| status_byte | output | 8 | 0xF8 OR the serial output bit |
| tick | output | 1 | Single-cycle periodic interrupt pulse |

## Verification
The bench builds the block with CLK_HZ set to 16384. This makes the three tick periods 256, 64 and 8 cycles, so the first-tick delay and the tick spacing can be measured exactly within a short run. The 48-bit frame is read out by shifting in mode 1 with data-in low, so every loaded field is compared bit by bit. The date vectors include the largest legal field values, which exercises the BCD conversion at its upper digits.

// File: rtl/calclk_pkg.sv
package calclk_pkg;

  localparam int SR_W    = 48;
  localparam int INS_POS = 40;

  localparam int KIND_BIT = 2;
  localparam int STB_BIT  = 3;
  localparam int SCK_BIT  = 4;
  localparam int DIN_BIT  = 5;

  typedef enum logic [1:0] {
    RATE_SLOW = 2'd0,
    RATE_MID  = 2'd1,
    RATE_FAST = 2'd2,
    RATE_OFF  = 2'd3
  } rate_e;

  typedef struct packed {
    logic [6:0] year;
    logic [3:0] mon;
    logic [2:0] wday;
    logic [4:0] mday;
    logic [4:0] hour;
    logic [5:0] min;
    logic [5:0] sec;
  } caltime_t;

  // two-digit binary value to packed BCD, tens digit in the upper nibble
  function automatic logic [7:0] to_bcd(input logic [6:0] v);
    logic [6:0] tens;
    logic [6:0] ones;
    tens = v / 7'd10;
    ones = v % 7'd10;
    return {tens[3:0], ones[3:0]};
  endfunction

  function automatic logic [SR_W-1:0] pack_time(input caltime_t t);
    logic [SR_W-1:0] r;
    r        = '0;
    r[7:0]   = to_bcd({1'b0, t.sec});
    r[15:8]  = to_bcd({1'b0, t.min});
    r[23:16] = to_bcd({2'b0, t.hour});
    r[31:24] = to_bcd({2'b0, t.mday});
    r[35:32] = {1'b0, t.wday};
    r[39:36] = t.mon;
    r[47:40] = to_bcd(t.year);
    return r;
  endfunction

  function automatic logic [SR_W-1:0] shift_step(input logic [SR_W-1:0] sr,
                                                 input logic din);
    logic [SR_W-1:0] m;
    m          = sr;
    m[INS_POS] = m[INS_POS] | din;
    return m >> 1;
  endfunction

  function automatic int unsigned rate_period(input rate_e r, input int unsigned hz);
    case (r)
      RATE_SLOW: return hz / 64;
      RATE_MID:  return hz / 256;
      RATE_FAST: return hz / 2048;
      default:   return 0;
    endcase
  endfunction

endpackage

// File: rtl/calclk_cmd_decode.sv
module calclk_cmd_decode
  import calclk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_we,
  input  logic [7:0] cmd_wdata,
  output logic       load_o,
  output logic       shift_o,
  output logic       din_o,
  output rate_e      rate_o
);

  logic [7:0] prev_q;
  logic [1:0] mode_q;
  rate_e      rate_q;

  // named internal events
  logic       strobe_fall;
  logic       sclk_rise;
  logic       is_rate_cmd;
  logic [1:0] mode_eff;

  assign strobe_fall = cmd_we && prev_q[STB_BIT] && !cmd_wdata[STB_BIT] && !prev_q[SCK_BIT];
  assign sclk_rise   = cmd_we && !prev_q[SCK_BIT] && cmd_wdata[SCK_BIT];
  assign is_rate_cmd = prev_q[KIND_BIT];

  always_comb begin
    mode_eff = mode_q;
    if (strobe_fall && !is_rate_cmd) mode_eff = prev_q[1:0];
  end

  assign load_o  = strobe_fall && !is_rate_cmd && (prev_q[1:0] == 2'd3);
  assign shift_o = sclk_rise && (mode_eff == 2'd1);
  assign din_o   = prev_q[DIN_BIT];
  assign rate_o  = rate_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 8'h10;
      mode_q <= 2'd0;
      rate_q <= RATE_OFF;
    end else if (cmd_we) begin
      prev_q <= cmd_wdata;
      if (strobe_fall) begin
        if (is_rate_cmd) rate_q <= rate_e'(prev_q[1:0]);
        else             mode_q <= prev_q[1:0];
      end
    end
  end

  a_r10_sclk_high_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && prev_q[SCK_BIT]) |=> ($stable(mode_q) && $stable(rate_q)));

  a_r2_idle_holds_state: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_we |=> ($stable(mode_q) && $stable(rate_q) && $stable(prev_q)));

  a_r4_rate_keeps_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && is_rate_cmd) |=> $stable(mode_q));

endmodule

// File: rtl/calclk_shifter.sv
module calclk_shifter
  import calclk_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     load_i,
  input  logic     shift_i,
  input  logic     din_i,
  input  caltime_t now_i,
  output logic     sout_o
);

  logic [SR_W-1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sr_q <= '0;
    else if (load_i)  sr_q <= pack_time(now_i);
    else if (shift_i) sr_q <= shift_step(sr_q, din_i);
  end

  assign sout_o = sr_q[0];

  a_r8_hold_without_event: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !shift_i) |=> $stable(sr_q));

  a_r6_top_bit_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_i && !load_i) |=> !sr_q[SR_W-1]);

  a_r11_seconds_bcd: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && now_i.sec < 6'd60) |=> (sr_q[3:0] <= 4'd9 && sr_q[7:4] <= 4'd5));

endmodule

// File: rtl/calclk_ticker.sv
module calclk_ticker
  import calclk_pkg::*;
#(
  parameter int unsigned CLK_HZ = 1048576
) (
  input  logic  clk,
  input  logic  rst_n,
  input  rate_e rate_i,
  output logic  tick_o
);

  localparam int unsigned P_SLOW = CLK_HZ / 64;
  localparam int unsigned P_MID  = CLK_HZ / 256;
  localparam int unsigned P_FAST = CLK_HZ / 2048;
  localparam int unsigned CNT_W  = $clog2(P_SLOW + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;
  logic             wrap;

  always_comb begin
    case (rate_i)
      RATE_SLOW: limit = CNT_W'(P_SLOW - 1);
      RATE_MID:  limit = CNT_W'(P_MID - 1);
      RATE_FAST: limit = CNT_W'(P_FAST - 1);
      default:   limit = '0;
    endcase
  end

  assign wrap = (rate_i != RATE_OFF) && (cnt_q >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else if (rate_i == RATE_OFF) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else begin
      tick_o <= wrap;
      cnt_q  <= wrap ? '0 : cnt_q + 1'b1;
    end
  end

  a_r3_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o);

  a_r2_stopped_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_i == RATE_OFF) |=> !tick_o);

  a_r3_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CNT_W'(P_SLOW));

endmodule

// File: rtl/calclk_top.sv
module calclk_top
  import calclk_pkg::*;
#(
  parameter int unsigned CLK_HZ = 1048576
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_we,
  input  logic [7:0] cmd_wdata,
  input  logic [5:0] now_sec,
  input  logic [5:0] now_min,
  input  logic [4:0] now_hour,
  input  logic [4:0] now_mday,
  input  logic [2:0] now_wday,
  input  logic [3:0] now_mon,
  input  logic [6:0] now_year,
  output logic [7:0] status_byte,
  output logic       tick
);

  logic     load_w;
  logic     shift_w;
  logic     din_w;
  logic     sout_w;
  rate_e    rate_w;
  caltime_t now_w;

  always_comb begin
    now_w.sec  = now_sec;
    now_w.min  = now_min;
    now_w.hour = now_hour;
    now_w.mday = now_mday;
    now_w.wday = now_wday;
    now_w.mon  = now_mon;
    now_w.year = now_year;
  end

  calclk_cmd_decode u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_we    (cmd_we),
    .cmd_wdata (cmd_wdata),
    .load_o    (load_w),
    .shift_o   (shift_w),
    .din_o     (din_w),
    .rate_o    (rate_w)
  );

  calclk_shifter u_sh (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (load_w),
    .shift_i (shift_w),
    .din_i   (din_w),
    .now_i   (now_w),
    .sout_o  (sout_w)
  );

  calclk_ticker #(.CLK_HZ(CLK_HZ)) u_tk (
    .clk    (clk),
    .rst_n  (rst_n),
    .rate_i (rate_w),
    .tick_o (tick)
  );

  assign status_byte = 8'hF8 | {7'd0, sout_w};

  a_r1_load_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    load_w |-> (cmd_we && !cmd_wdata[STB_BIT]));

  a_r7_status_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_we |=> $stable(status_byte));

endmodule

// File: tb/calclk_top_bench.sv
module calclk_top_bench;

  localparam int unsigned HZ = 16384;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_we = 1'b0;
  logic [7:0] cmd_wdata = 8'h00;
  logic [5:0] now_sec = '0;
  logic [5:0] now_min = '0;
  logic [4:0] now_hour = '0;
  logic [4:0] now_mday = '0;
  logic [2:0] now_wday = '0;
  logic [3:0] now_mon = '0;
  logic [6:0] now_year = '0;
  logic [7:0] status_byte;
  logic       tick;

  int n_checks = 0;
  int n_fail   = 0;

  always #4 clk = ~clk;

  calclk_top #(.CLK_HZ(HZ)) u_calclk_top (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
    .now_sec(now_sec), .now_min(now_min), .now_hour(now_hour),
    .now_mday(now_mday), .now_wday(now_wday), .now_mon(now_mon),
    .now_year(now_year), .status_byte(status_byte), .tick(tick)
  );

  // packed vectors: {year7, mon4, wday3, mday5, hour5, min6, sec6}
  localparam logic [35:0] VEC [4] = '{
    {7'd0,  4'd0,  3'd0, 5'd1,  5'd0,  6'd0,  6'd0},
    {7'd99, 4'd11, 3'd6, 5'd31, 5'd23, 6'd59, 6'd59},
    {7'd24, 4'd4,  3'd3, 5'd15, 5'd13, 6'd42, 6'd7},
    {7'd80, 4'd1,  3'd5, 5'd28, 5'd9,  6'd5,  6'd30}
  };

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] dec2(input int v);
    int t;
    t = 0;
    while (v >= 10) begin v -= 10; t++; end
    return 8'((t << 4) + v);
  endfunction

  function automatic logic [47:0] frame_of(input logic [35:0] v);
    logic [47:0] f;
    f = {dec2(int'(v[35:29])), v[28:25], 1'b0, v[24:22],
         dec2(int'(v[21:17])), dec2(int'(v[16:12])),
         dec2(int'(v[11:6])), dec2(int'(v[5:0]))};
    return f;
  endfunction

  task automatic set_time(input logic [35:0] v);
    now_year = v[35:29]; now_mon = v[28:25]; now_wday = v[24:22];
    now_mday = v[21:17]; now_hour = v[16:12]; now_min = v[11:6]; now_sec = v[5:0];
  endtask

  task automatic wr(input logic [7:0] b);
    @(negedge clk); cmd_we = 1'b1; cmd_wdata = b;
    @(negedge clk); cmd_we = 1'b0;
  endtask

  // strobe high with low bits, then strobe low: latches on the second write
  task automatic command(input logic [2:0] c);
    wr({5'b00001, c});
    wr(8'h00);
  endtask

  task automatic read_frame(output logic [47:0] f);
    for (int i = 0; i < 48; i++) begin
      f[i] = status_byte[0];
      wr(8'h00);
      wr(8'h10);
    end
  endtask

  task automatic first_tick(output int k);
    k = 0;
    while (!tick && k < 2000) begin @(negedge clk); k++; end
  endtask

  task automatic spacing(output int k);
    k = 0;
    do begin @(negedge clk); k++; end while (!tick && k < 2000);
  endtask

  initial begin
    #2_000_000;
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [47:0] f;
    int k;
    int seen;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 reset state
    check(status_byte == 8'hF8, "R9 status after reset", status_byte, 8'hF8);
    seen = 0;
    repeat (600) begin @(negedge clk); if (tick) seen++; end
    check(seen == 0, "R9 tick stopped after reset", seen, 0);

    // R5 R11 R7 R4 R1: table walk, load with mode 3 then read out in mode 1
    foreach (VEC[i]) begin
      set_time(VEC[i]);
      command(3'd3);
      check(status_byte == (8'hF8 | {7'd0, frame_of(VEC[i])[0]}), "R7 status after load",
            status_byte, 8'hF8 | {7'd0, frame_of(VEC[i])[0]});
      command(3'd1);
      read_frame(f);
      check(f == frame_of(VEC[i]), "R5 R11 loaded frame", f, frame_of(VEC[i]));
    end

    // R6 data-in inserted at bit 40 then shifted; register is empty here
    wr(8'h20);
    wr(8'h30);
    check(status_byte[0] == 1'b0, "R6 bit0 right after insert", status_byte[0], 0);
    for (int i = 0; i < 39; i++) begin wr(8'h00); wr(8'h10); end
    check(status_byte == 8'hF9, "R6 inserted bit reaches bit0", status_byte, 8'hF9);
    wr(8'h00); wr(8'h10);
    check(status_byte == 8'hF8, "R6 inserted bit shifted out", status_byte, 8'hF8);

    // R10 strobe fall with shift clock high is ignored (register stays empty)
    set_time(VEC[1]);
    wr(8'h1B);
    wr(8'h10);
    read_frame(f);
    check(f == 48'd0, "R10 no load with shift clock high", f, 0);

    // R8 rises in mode 0 do not shift
    set_time(VEC[2]);
    command(3'd3);
    command(3'd0);
    for (int i = 0; i < 5; i++) begin wr(8'h00); wr(8'h10); end
    check(status_byte[0] == frame_of(VEC[2])[0], "R8 bit0 held in mode 0",
          status_byte[0], frame_of(VEC[2])[0]);
    command(3'd1);
    read_frame(f);
    check(f == frame_of(VEC[2]), "R8 frame intact after mode 0 rises", f, frame_of(VEC[2]));

    // R2 R3 fast rate from stopped
    command(3'd6);
    first_tick(k);
    check(k == 8, "R3 first tick delay rate 2", k, 8);
    @(negedge clk);
    check(tick == 1'b0, "R3 tick one cycle wide", tick, 0);
    spacing(k);
    check(k == 7, "R2 rate 2 spacing after drop", k, 7);

    // R2 stop
    command(3'd7);
    seen = 0;
    repeat (600) begin @(negedge clk); if (tick) seen++; end
    check(seen == 0, "R2 rate 3 stops tick", seen, 0);

    // R2 R3 slow rate from stopped
    command(3'd4);
    first_tick(k);
    check(k == 256, "R3 first tick delay rate 0", k, 256);
    spacing(k);
    check(k == 256, "R2 rate 0 period", k, 256);

    // R2 mid rate from stopped
    command(3'd7);
    command(3'd5);
    first_tick(k);
    check(k == 64, "R3 first tick delay rate 1", k, 64);
    spacing(k);
    check(k == 64, "R2 rate 1 period", k, 64);

    // R4 rate command left mode 1 in place: shifting still works
    set_time(VEC[3]);
    command(3'd7);
    command(3'd3);
    command(3'd1);
    read_frame(f);
    check(f == frame_of(VEC[3]), "R4 mode kept across rate commands", f, frame_of(VEC[3]));

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule